// File: doc/BRIEF.md
# Operand-Case Functional Unit Steering

This block sits between the issue stage and a bank of four identical functional-unit modules. Every cycle up to four operations arrive, each with a valid bit and a 2-bit operand case code. The block decides which module each operation goes to. The aim is for a given module to keep seeing the same kind of operand from one cycle to the next, which lowers switching activity inside the modules. Only the current cycle's codes are used, and no operand history is kept.

The four case codes are packed into an 8-bit address. A slot with no operation is filled with a pad code, set by a parameter, that stands for the rarest case. A lookup function turns that address into a full permutation of module indices. A parameter picks one of two reservation policies. The integer policy reserves modules 0 to 2 for case 00 and sends every other case to module 3. The floating-point policy gives case k its own module k. The result is registered, so it appears one cycle after issue.

Top module: `fu_steer`

## Requirements
- R1: While rstN is low, every bit of unitValid and unitIdx reads 0.
- R2: unitValid equals the opValid presented one rising clock edge earlier. The matching unitIdx appears on the same edge.
- R3: Two slots whose unitValid bits are both 1 never carry the same module index. Slot s uses bits [2s+1:2s] of opCase and unitIdx.
- R4: With the integer policy (POLICY = 0), the reserved set for case 00 is modules {0,1,2}. The reserved set for cases 01, 10 and 11 is module {3}.
- R5: With the floating-point policy (POLICY = 1), the reserved set for case k is module k alone.
- R6: Slots are placed in order 0, 1, 2, 3. Each slot takes the lowest-numbered module that is still free and reserved for its case.
- R7: A slot with no free reserved module takes the lowest-numbered free module of any kind.
- R8: A slot whose opValid bit is 0 is placed as if its case were PAD_CASE (default 11). It still uses up a module in slot order. Its opCase bits have no effect on any output, and its unitValid bit is 0.
- R9: In a cycle with no opValid bit set, unitValid becomes 0 on the next edge and unitIdx keeps its previous value.
- R10: The mapping depends only on the current cycle's inputs. The same opValid and opCase give the same unitIdx whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 4 | Per-slot operation-present bit |
| opCase | input | 8 | Per-slot 2-bit operand case code, slot s at [2s+1:2s] |
| unitIdx | output | 8 | Per-slot 2-bit module index, slot s at [2s+1:2s] |
| unitValid | output | 4 | Per-slot valid bit for unitIdx |

## Verification
Padding and overflow can both occur in the same cycle. An empty slot padded with the rarest case can take the module reserved for that case, so a later real operation of that case has to overflow to the lowest free module. The bench provokes this with the floating-point policy: slot 0 is left empty and slot 1 carries case 11, so slot 1 must land on module 0 rather than 3. A second cycle then changes only the empty slot's case bits, and the bench checks that the result is identical. Both policies are built side by side and driven with the same stimulus. Each full 8-bit permutation is compared against a model written from the rules above.

// File: rtl/fu_steer_pkg.sv
package fu_steer_pkg;
  localparam int UNITS  = 4;
  localparam int CASE_W = 2;
  localparam int IDX_W  = $clog2(UNITS);
  localparam int VEC_W  = UNITS * CASE_W;
  localparam int MAP_W  = UNITS * IDX_W;
  localparam int NCASE  = 1 << CASE_W;

  typedef enum logic {
    POL_INT = 1'b0,
    POL_FP  = 1'b1
  } policy_e;

  typedef struct packed {
    logic             loadIdx;
    logic [UNITS-1:0] padMask;
    logic [UNITS-1:0] validNext;
  } steer_strb_t;
endpackage

// File: rtl/fu_steer_ctrl.sv
module fu_steer_ctrl import fu_steer_pkg::*; (
  input  logic [UNITS-1:0] opValid,
  output steer_strb_t      strb
);
  always_comb begin
    strb.loadIdx   = |opValid;
    strb.padMask   = ~opValid;
    strb.validNext = opValid;
  end
endmodule

// File: rtl/fu_steer_lut.sv
module fu_steer_lut import fu_steer_pkg::*; #(
  parameter policy_e POLICY = POL_INT
) (
  input  logic [VEC_W-1:0] caseVec,
  output logic [MAP_W-1:0] unitMap
);
  logic [UNITS-1:0] resvMask [NCASE];

  generate
    if (POLICY == POL_INT) begin : g_int
      always_comb begin
        for (int c = 0; c < NCASE; c++) begin
          if (c == 0) resvMask[c] = {1'b0, {(UNITS-1){1'b1}}};
          else        resvMask[c] = UNITS'(1) << (UNITS-1);
        end
      end
    end else begin : g_fp
      always_comb begin
        for (int c = 0; c < NCASE; c++) begin
          resvMask[c] = UNITS'(1) << (c % UNITS);
        end
      end
    end
  endgenerate

  function automatic logic [IDX_W-1:0] lowestSet(input logic [UNITS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = UNITS-1; k >= 0; k--) begin
      if (m[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  always_comb begin
    logic [UNITS-1:0]  freeM;
    logic [UNITS-1:0]  cand;
    logic [IDX_W-1:0]  pick;
    logic [CASE_W-1:0] cs;
    freeM   = '1;
    unitMap = '0;
    for (int s = 0; s < UNITS; s++) begin
      cs   = caseVec[s*CASE_W +: CASE_W];
      cand = resvMask[cs] & freeM;
      if (cand != '0) pick = lowestSet(cand);
      else            pick = lowestSet(freeM);
      unitMap[s*IDX_W +: IDX_W] = pick;
      freeM[pick] = 1'b0;
    end
  end
endmodule

// File: rtl/fu_steer_dp.sv
module fu_steer_dp import fu_steer_pkg::*; #(
  parameter policy_e           POLICY   = POL_INT,
  parameter logic [CASE_W-1:0] PAD_CASE = 2'b11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [UNITS-1:0] opValid,
  input  logic [VEC_W-1:0] opCase,
  input  steer_strb_t      strb,
  output logic [MAP_W-1:0] unitIdx,
  output logic [UNITS-1:0] unitValid
);
  logic [VEC_W-1:0] caseVec;
  logic [MAP_W-1:0] unitMap;

  generate
    for (genvar s = 0; s < UNITS; s++) begin : g_pack
      assign caseVec[s*CASE_W +: CASE_W] =
        strb.padMask[s] ? PAD_CASE : opCase[s*CASE_W +: CASE_W];
    end
  endgenerate

  fu_steer_lut #(.POLICY(POLICY)) u_lut (
    .caseVec (caseVec),
    .unitMap (unitMap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitIdx   <= '0;
      unitValid <= '0;
    end else begin
      unitValid <= strb.validNext;
      if (strb.loadIdx) unitIdx <= unitMap;
    end
  end

  // R2: valid output follows issue with one edge of latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> unitValid == $past(opValid));

  // R9: idle cycle clears valids and freezes indices
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid == '0) |=> (unitValid == '0) && $stable(unitIdx));

  // R3: no two live slots share a module
  generate
    for (genvar i = 0; i < UNITS; i++) begin : g_pi
      for (genvar j = i + 1; j < UNITS; j++) begin : g_pj
        a_r3_distinct: assert property (@(posedge clk) disable iff (!rstN)
          (unitValid[i] && unitValid[j]) |->
            unitIdx[i*IDX_W +: IDX_W] != unitIdx[j*IDX_W +: IDX_W]);
      end
    end
    if (POLICY == POL_INT) begin : g_a_int
      // R4: slot 0 always lands in its reserved set
      a_r4_slot0_zero: assert property (@(posedge clk) disable iff (!rstN)
        (opValid[0] && opCase[CASE_W-1:0] == '0) |=>
          unitIdx[IDX_W-1:0] != IDX_W'(UNITS-1));
      a_r4_slot0_other: assert property (@(posedge clk) disable iff (!rstN)
        (opValid[0] && opCase[CASE_W-1:0] != '0) |=>
          unitIdx[IDX_W-1:0] == IDX_W'(UNITS-1));
    end else begin : g_a_fp
      // R5: slot 0 always lands on the module of its own case
      a_r5_slot0_home: assert property (@(posedge clk) disable iff (!rstN)
        opValid[0] |=> unitIdx[IDX_W-1:0] == IDX_W'($past(opCase[CASE_W-1:0])));
    end
  endgenerate
endmodule

// File: rtl/fu_steer.sv
module fu_steer import fu_steer_pkg::*; #(
  parameter policy_e           POLICY   = POL_INT,
  parameter logic [CASE_W-1:0] PAD_CASE = 2'b11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [UNITS-1:0] opValid,
  input  logic [VEC_W-1:0] opCase,
  output logic [MAP_W-1:0] unitIdx,
  output logic [UNITS-1:0] unitValid
);
  steer_strb_t strb;

  fu_steer_ctrl u_ctrl (
    .opValid (opValid),
    .strb    (strb)
  );

  fu_steer_dp #(.POLICY(POLICY), .PAD_CASE(PAD_CASE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCase    (opCase),
    .strb      (strb),
    .unitIdx   (unitIdx),
    .unitValid (unitValid)
  );

  // R1: reset state is visible at the ports
  always_comb begin
    if (!rstN) begin
      a_r1_reset_clear: assert (unitValid == '0 && unitIdx == '0);
    end
  end
endmodule

// File: tb/fu_steer_bench.sv
module fu_steer_bench;
  import fu_steer_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opValid = '0;
  logic [7:0] opCase = '0;
  logic [7:0] idxI, idxF;
  logic [3:0] vldI, vldF;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] eIdxI;
    logic [7:0] eIdxF;
    logic [3:0] eVld;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic [7:0] lastI = '0, lastF = '0;

  always #5ns clk = ~clk;

  fu_steer #(.POLICY(POL_INT), .PAD_CASE(2'b11)) u_fu_steer (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCase(opCase),
    .unitIdx(idxI), .unitValid(vldI));

  fu_steer #(.POLICY(POL_FP), .PAD_CASE(2'b11)) u_fu_steer_fp (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCase(opCase),
    .unitIdx(idxF), .unitValid(vldF));

  function automatic logic [7:0] refMap(bit fp, logic [3:0] v, logic [7:0] c);
    bit [3:0]   used = '0;
    logic [7:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      logic [1:0] cs;
      bit   [3:0] home;
      int         pick = -1;
      cs = v[s] ? c[2*s +: 2] : 2'b11;
      if (fp)            home = 4'b0001 << cs;
      else if (cs == 0)  home = 4'b0111;
      else               home = 4'b1000;
      for (int u = 0; u < 4; u++) if (home[u] && !used[u] && pick < 0) pick = u;
      for (int u = 0; u < 4; u++) if (!used[u] && pick < 0) pick = u;
      used[pick] = 1'b1;
      r[2*s +: 2] = 2'(pick);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] v, logic [7:0] c, string tag);
    exp_t e;
    @(negedge clk);
    opValid = v;
    opCase  = c;
    if (v != 0) begin
      lastI = refMap(0, v, c);
      lastF = refMap(1, v, c);
    end
    e.eIdxI = lastI;
    e.eIdxF = lastF;
    e.eVld  = v;
    e.tag   = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2ns;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " int unitIdx"}, 32'(idxI), 32'(e.eIdxI));
        check({e.tag, " fp unitIdx"},  32'(idxF), 32'(e.eIdxF));
        check("R2 int unitValid", 32'(vldI), 32'(e.eVld));
        check("R2 fp unitValid",  32'(vldF), 32'(e.eVld));
        for (int i = 0; i < 4; i++)
          for (int j = i + 1; j < 4; j++)
            if (vldF[i] && vldF[j])
              check("R3 fp distinct", 32'(idxF[2*i +: 2] == idxF[2*j +: 2]), 32'(0));
      end
    end
  end

  initial begin : watchdog
    #2000us;
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 int reset", {20'b0, vldI, idxI}, 32'(0));
    check("R1 fp reset",  {20'b0, vldF, idxF}, 32'(0));
    rstN = 1'b1;

    // R4 R5: distinct cases 00,01,10,11 in slots 0..3
    apply(4'b1111, {2'b11, 2'b10, 2'b01, 2'b00}, "R5");
    // R7: all case 00, integer slot 3 and fp slots 1..3 overflow
    apply(4'b1111, 8'h00, "R7");
    // R6: reversed order
    apply(4'b1111, {2'b00, 2'b01, 2'b10, 2'b11}, "R6");
    // R4: single case 00 in slot 2
    apply(4'b0100, {2'b01, 2'b00, 2'b10, 2'b01}, "R4");
    // R8: padded slot 0 takes module 3 before real case 11 in slot 1
    apply(4'b0010, {2'b00, 2'b00, 2'b11, 2'b11}, "R8");
    apply(4'b0010, {2'b00, 2'b00, 2'b11, 2'b01}, "R8 ignored case");
    // R9: idle holds indices, clears valids
    apply(4'b0000, 8'hA5, "R9");
    apply(4'b0000, 8'h3C, "R9");
    // R10: same pattern after different history
    apply(4'b1011, 8'h1B, "R10");
    apply(4'b1111, 8'hFF, "R7");
    apply(4'b1011, 8'h1B, "R10");
    // R6 R7: sweep of masks and codes
    for (int m = 1; m < 16; m++)
      for (int k = 0; k < 16; k++)
        apply(4'(m), 8'(k * 37 + m * 11), "R6");
    @(negedge clk);
    opValid = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule